// File: doc/BRIEF.md
# Mono-to-Grayscale Nibble Expander

This block sits between a source of 1-bit monochrome pixel data and the write path of a 4-bit grayscale display controller. Monochrome pixels arrive packed eight to a byte. The block turns each pixel into one to four identical 4-bit segments. A lit pixel becomes all ones and a dark pixel becomes all zeros. It packs two segments into each output byte.

A transfer begins with a one-cycle `start` pulse. On that pulse the block captures the number of pixels in the transfer and the replication factor. After that it pulls exactly as many input bytes as the pixel count needs. It pushes out exactly as many bytes as the segment count fills.

Both data sides use valid/ready handshakes. A byte moves on a clock edge where valid and ready are both high. The source may present data at any time; the block takes a byte only while `in_ready` is high. The block drops `in_ready` while it still holds pixels of the current byte that it has not expanded. Once `out_valid` is high, it stays high with `out_data` unchanged until the sink raises `out_ready`. If the sink holds `out_ready` low, the stall reaches the input within a few cycles.

Top module: `mono_gray_expander`

## Requirements
- R1: While reset is held and after its release, `out_valid`, `in_ready`, `busy` and `done` are all low.
- R2: A `start` pulse while `busy` is low captures `pix_total` and `seg_per_pix_m1`, and `busy` is high in the following cycle when `pix_total` is nonzero. A `start` pulse while `busy` is high is ignored, and the running transfer's output is unchanged.
- R3: Pixel k of a transfer is taken from input byte k/8 at bit position k mod 8, starting at bit 0. A 1 bit yields segment value 0xF and a 0 bit yields 0x0.
- R4: Each pixel produces `seg_per_pix_m1`+1 consecutive segments (the encoding is 0 for one segment up to 3 for four).
- R5: Segments fill output bytes in order. The earlier segment of a byte goes in bits [3:0] and the later one in bits [7:4].
- R6: A transfer of P pixels with S segments per pixel emits exactly ceil(P*S/2) bytes. When P*S is odd, the last byte carries its segment in bits [3:0] and has bits [7:4] zero.
- R7: A transfer accepts exactly ceil(P/8) input bytes. Any bits of the last byte beyond pixel P-1 have no effect, and no further byte is taken after that.
- R8: `in_ready` is low while the current input byte still has pixels to expand, so an output stall holds input acceptance at one byte once the internal stages are full.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged in the next cycle.
- R10: `done` is a one-cycle pulse in the cycle after the last output byte is accepted, and `busy` is low in that same cycle. With `pix_total` equal to zero, `done` pulses in the cycle after `start` and no byte is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transfer when idle |
| pix_total | input | PIX_W | Pixel count of the transfer, captured at start |
| seg_per_pix_m1 | input | 2 | Segments per pixel minus one, captured at start |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Eight mono pixels, bit 0 first |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Two grayscale segments, earlier one in bits [3:0] |
| out_ready | input | 1 | Sink accepts the output byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last output byte is accepted |

## Verification
A wrong bit index or repeat counter shows up in the first output byte it touches as a misplaced or wrongly repeated nibble, and a stray count shows as one byte too many or too few at the end of the transfer. A wrong pixel-remaining count also shows up as an extra or missing input acceptance, visible as soon as the last input byte has been consumed. A fault in the hold logic changes `out_data` during a stall in the very next cycle. A fault in completion tracking moves the `done` pulse off the cycle that follows the final acceptance.

// File: rtl/mge_pkg.sv
package mge_pkg;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int PIX_PER_B  = BYTE_W;
  localparam int BIDX_W     = $clog2(PIX_PER_B);
  localparam int REP_W      = 2;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic nib_t expand_bit(input logic b);
    return {NIB_W{b}};
  endfunction
endpackage

// File: rtl/mge_src.sv
module mge_src
  import mge_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] pix_total,
  input  logic [REP_W-1:0] rep_m1,
  input  logic             in_valid,
  input  byte_t            in_data,
  output logic             in_ready,
  output logic             nib_valid,
  output nib_t             nib,
  output logic             nib_last,
  input  logic             nib_ready
);
  logic [PIX_W-1:0]  pix_left;
  byte_t             byte_q;
  logic              have_byte;
  logic [BIDX_W-1:0] bit_idx;
  logic [REP_W-1:0]  rep_cnt;
  logic [REP_W-1:0]  rep_q;

  logic pix_end;
  logic fire;

  assign in_ready  = !have_byte && (pix_left != '0);
  assign nib_valid = have_byte;
  assign nib       = expand_bit(byte_q[bit_idx]);
  assign pix_end   = (rep_cnt == rep_q);
  assign nib_last  = pix_end && (pix_left == PIX_W'(1));
  assign fire      = have_byte && nib_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_left  <= '0;
      byte_q    <= '0;
      have_byte <= 1'b0;
      bit_idx   <= '0;
      rep_cnt   <= '0;
      rep_q     <= '0;
    end else if (load) begin
      pix_left  <= pix_total;
      rep_q     <= rep_m1;
      rep_cnt   <= '0;
      have_byte <= 1'b0;
      bit_idx   <= '0;
    end else begin
      if (in_valid && in_ready) begin
        byte_q    <= in_data;
        have_byte <= 1'b1;
        bit_idx   <= '0;
      end
      if (fire) begin
        if (pix_end) begin
          rep_cnt  <= '0;
          pix_left <= pix_left - PIX_W'(1);
          bit_idx  <= bit_idx + BIDX_W'(1);
          if (bit_idx == BIDX_W'(PIX_PER_B - 1) || pix_left == PIX_W'(1))
            have_byte <= 1'b0;
        end else begin
          rep_cnt <= rep_cnt + REP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mge_packer.sv
module mge_packer
  import mge_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  nib_valid,
  input  nib_t  nib,
  input  logic  nib_last,
  output logic  nib_ready,
  output logic  out_valid,
  output byte_t out_data,
  input  logic  out_ready,
  output logic  last_taken
);
  nib_t  lo_q;
  logic  lo_full;
  byte_t out_q;
  logic  valid_q;
  logic  last_q;
  logic  take;

  assign nib_ready  = !valid_q || out_ready;
  assign take       = valid_q && out_ready;
  assign last_taken = take && last_q;
  assign out_valid  = valid_q;
  assign out_data   = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q    <= '0;
      lo_full <= 1'b0;
      out_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      if (take) valid_q <= 1'b0;
      if (nib_valid && nib_ready) begin
        if (lo_full || nib_last) begin
          out_q   <= lo_full ? {nib, lo_q} : {nib_t'(0), nib};
          valid_q <= 1'b1;
          last_q  <= nib_last;
          lo_full <= 1'b0;
        end else begin
          lo_q    <= nib;
          lo_full <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mono_gray_expander.sv
module mono_gray_expander
  import mge_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PIX_W-1:0] pix_total,
  input  logic [1:0]       seg_per_pix_m1,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             busy,
  output logic             done
);
  logic start_ok;
  logic nib_valid, nib_last, nib_ready, last_taken;
  nib_t nib;

  assign start_ok = start && !busy;

  mge_src #(.PIX_W(PIX_W)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .pix_total (pix_total),
    .rep_m1    (seg_per_pix_m1),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .nib_valid (nib_valid),
    .nib       (nib),
    .nib_last  (nib_last),
    .nib_ready (nib_ready)
  );

  mge_packer u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_valid  (nib_valid),
    .nib        (nib),
    .nib_last   (nib_last),
    .nib_ready  (nib_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .last_taken (last_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= last_taken || (start_ok && pix_total == '0);
      if (start_ok && pix_total != '0) busy <= 1'b1;
      else if (last_taken)             busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mge_chk.sv
module mge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_no_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_idle_no_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_nibble_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data[3:0] == 4'h0 || out_data[3:0] == 4'hF) &&
                   (out_data[7:4] == 4'h0 || out_data[7:4] == 4'hF)));
endmodule

bind mono_gray_expander mge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/mono_gray_expander_tb.sv
module mono_gray_expander_tb;
  localparam int PIX_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PIX_W-1:0] pix_total = '0;
  logic [1:0] seg_per_pix_m1 = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, busy, done;
  logic [7:0] out_data;
  logic out_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] mem [0:7];
  logic [3:0] segs [0:255];
  logic [7:0] exp_b [0:127];

  always #10 clk = ~clk;

  mono_gray_expander #(.PIX_W(PIX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_total(pix_total),
    .seg_per_pix_m1(seg_per_pix_m1), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic run(input int P, input int S, input int stall, input bit poke);
    int nbytes, nexp, nseg, iacc, oidx, iter, done_iter, last_fire;
    bit in_pend, done_seen, have_first;
    logic [7:0] first_b;
    nbytes = (P + 7) / 8;
    nseg = P * S;
    nexp = (nseg + 1) / 2;
    for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
    for (int p = 0; p < P; p++)
      for (int r = 0; r < S; r++)
        segs[p*S + r] = mem[p/8][p%8] ? 4'hF : 4'h0;
    for (int j = 0; j < nexp; j++)
      exp_b[j] = {(2*j+1 < nseg) ? segs[2*j+1] : 4'h0, segs[2*j]};
    @(negedge clk);
    pix_total = PIX_W'(P);
    seg_per_pix_m1 = 2'(S - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pix_total = PIX_W'(7);
    seg_per_pix_m1 = 2'd0;
    check("R2 busy after start", int'(busy), (P != 0) ? 1 : 0);
    iacc = 0; oidx = 0; iter = 0; in_pend = 0; done_seen = 0;
    done_iter = -1; last_fire = -1; have_first = 0; first_b = '0;
    while (!done_seen && iter < 3000) begin
      if (iter > 0) @(negedge clk);
      if (in_pend) iacc++;
      if (done) begin
        done_seen = 1;
        done_iter = iter;
        in_valid = 1'b0;
        out_ready = 1'b0;
        start = 1'b0;
      end else begin
        in_valid = ($urandom % 4) != 0;
        in_data = (iacc < nbytes) ? mem[iacc] : 8'($urandom);
        in_pend = in_valid && in_ready;
        if (iter == stall && stall > 0)
          check("R8 inputs taken during stall", iacc, 1);
        if (iter < stall) begin
          out_ready = 1'b0;
          if (out_valid) begin
            if (!have_first) begin
              have_first = 1;
              first_b = out_data;
            end else if (out_data != first_b || iter == stall - 1) begin
              check("R9 held byte", int'(out_data), int'(first_b));
            end
          end
        end else begin
          out_ready = ($urandom % 4) != 0;
        end
        if (out_valid && out_ready) begin
          if (oidx < nexp)
            check((oidx == nexp - 1 && nseg % 2 == 1) ? "R6 odd tail" : "R3/R4/R5 data",
                  int'(out_data), int'(exp_b[oidx]));
          oidx++;
          last_fire = iter;
        end
        if (poke && iter == 5) begin
          pix_total = PIX_W'(3);
          seg_per_pix_m1 = 2'd0;
          start = 1'b1;
        end else begin
          start = 1'b0;
        end
        iter++;
      end
    end
    check("R10 done seen", int'(done_seen), 1);
    check("R6 byte count", oidx, nexp);
    check("R7 input count", iacc, nbytes);
    check("R10 done timing", done_iter, (P == 0) ? 0 : last_fire + 1);
    @(negedge clk);
    check("R10 single pulse", int'(done), 0);
    check("R10 idle after", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", int'({out_valid, in_ready, busy, done}), 0);
    for (int s = 1; s <= 4; s++)
      for (int p = 0; p <= 40; p++)
        run(p, s, 0, 1'b0);
    run(16, 4, 20, 1'b0);
    run(40, 4, 0, 1'b1);
    run(9, 3, 12, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule